// File: doc/BRIEF.md
# ADC Burst Capture Buffer

This block records one burst of dual-channel converter samples into on-chip memory. The write side runs only on the clock that comes out of the converter. On every edge of that clock during a capture, it stores the two channel words as one packed entry. The capture lasts for exactly the configured number of entries. It then stops on its own, so the stored contents stay unchanged until the next capture.

The controlling side runs on a separate reader clock, for example the clock of a serial command interface. A single-cycle request on that clock starts a capture. The request crosses into the converter domain as a toggle. Completion comes back through another toggle, which drives the busy and done flags. Once done is high, the reader fetches entries in order through a registered read port, one strobe per entry. A request that arrives while a capture is still running has no effect.

Top module: `adc_capture_buffer`

## Requirements
- R1: Each entry is 2*CH_W bits wide, with channel A in the upper half (bits [2*CH_W-1:CH_W]) and channel B in the lower half (bits [CH_W-1:0]), both taken at the same converter clock edge.
- R2: A capture writes exactly DEPTH entries to addresses 0 to DEPTH-1, one per converter clock edge, from consecutive edges. It then stops writing, and the stored contents stay unchanged however many converter clocks follow.
- R3: A one-cycle `start_req` while `busy` is low is accepted. On the next reader clock edge `busy` is 1 and `done` is 0.
- R4: `busy` stays high until the last entry has been written and that completion has crossed into the reader domain. On the edge where `busy` falls, `done` rises. `busy` and `done` are never high together.
- R5: A `start_req` while `busy` is high is ignored. It produces no extra capture, and after the running capture ends, `busy` stays low.
- R6: `rd_en` is ignored while `done` is low. No `rd_valid` follows, and the read address does not move.
- R7: A read accepted at a reader clock edge presents its entry on `rd_data`, with `rd_valid` high, after the next reader clock edge (one cycle of latency).
- R8: The read address returns to 0 on every accepted start and advances by one on each accepted read. After entry DEPTH-1 it wraps to 0.
- R9: While `rd_rst_n` is low, and after it is released, `busy`, `done` and `rd_valid` are all 0 until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Reader/control clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, reader domain |
| start_req | input | 1 | One-cycle capture request (reader domain) |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Last capture complete, buffer readable |
| rd_en | input | 1 | Read strobe, one entry per cycle |
| rd_valid | output | 1 | `rd_data` holds the entry requested one cycle earlier |
| rd_data | output | 2*CH_W | Read entry {channel A, channel B} |
| adc_clk | input | 1 | Converter output clock |
| adc_rst_n | input | 1 | Synchronous active-low reset, converter domain |
| adc_ch_a | input | CH_W | Channel A sample |
| adc_ch_b | input | CH_W | Channel B sample |

## Verification
The bench drives each channel with a ramp, so every stored entry shows which converter edge it came from and whether its two halves belong together. Any of the following faults breaks the consecutive-entry chain over one full pass:
- a skipped or repeated write,
- channels swapped in the entry,
- a read address that moved on a strobe given before done,
- a read address not reset by a new start.

The wrap read and a reread of entry 0 after a long idle wait target a design that keeps writing past the end. A second start while busy targets a design that would start a second capture.

// File: rtl/cap_pkg.sv
// Package: default sizes shared by the capture buffer blocks.
// Assumes: nothing; constants only.
package cap_pkg;
    localparam int unsigned CAP_CH_W        = 12;
    localparam int unsigned CAP_DEPTH       = 4096;
    localparam int unsigned CAP_SYNC_STAGES = 2;
endpackage

// File: rtl/cap_toggle_sync.sv
// Toggle synchronizer: brings a level toggle into the destination clock
// domain and emits a one-cycle pulse per toggle.
// Assumes: the source toggles no faster than once per STAGES+1 dest cycles.
module cap_toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES:0] chain;

    // Shift the foreign toggle through the synchronizer flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], tog_in};
    end

    assign pulse = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/cap_dpram.sv
// Simple dual-clock memory: one write port, one registered read port.
// Assumes: caller never reads an address while it is being written.
module cap_dpram #(
    parameter int unsigned WIDTH = 24,
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_clk,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write port on the converter clock.
    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read port on the reader clock.
    always_ff @(posedge rd_clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/cap_write_ctrl.sv
// Write controller in the converter domain: on a start event it writes
// DEPTH consecutive entries from address 0, then stops and flips done_tog.
// Assumes: start_evt is a one-cycle synchronized pulse.
module cap_write_ctrl #(
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          adc_clk,
    input  logic          adc_rst_n,
    input  logic          start_evt,
    output logic          wr_busy,
    output logic [AW-1:0] wr_addr,
    output logic          done_tog
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Run the write address over one burst; starts are ignored while running.
    always_ff @(posedge adc_clk) begin
        if (!adc_rst_n) begin
            wr_busy  <= 1'b0;
            wr_addr  <= '0;
            done_tog <= 1'b0;
        end else if (wr_busy) begin
            if (wr_addr == LAST) begin
                wr_busy  <= 1'b0;
                done_tog <= ~done_tog;
            end else begin
                wr_addr <= wr_addr + AW'(1);
            end
        end else if (start_evt) begin
            wr_busy <= 1'b1;
            wr_addr <= '0;
        end
    end
endmodule

// File: rtl/cap_read_ctrl.sv
// Reader-domain control: accepts start requests, raises busy/done, and
// steps the read address on reads that are allowed.
// Assumes: done_evt is a synchronized pulse, one per finished capture.
module cap_read_ctrl #(
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          start_req,
    input  logic          done_evt,
    input  logic          rd_en,
    output logic          start_tog,
    output logic          armed,
    output logic          done_q,
    output logic          rd_fire,
    output logic [AW-1:0] rd_addr,
    output logic          rd_valid
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic accept;
    assign accept  = start_req & ~armed;
    assign rd_fire = rd_en & done_q;

    // Capture status: arm on an accepted start, finish on the returning event.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            start_tog <= 1'b0;
            armed     <= 1'b0;
            done_q    <= 1'b0;
        end else if (accept) begin
            start_tog <= ~start_tog;
            armed     <= 1'b1;
            done_q    <= 1'b0;
        end else if (done_evt) begin
            armed  <= 1'b0;
            done_q <= 1'b1;
        end
    end

    // Read address: zero on a new capture, step with wrap on each allowed read.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n || accept) rd_addr <= '0;
        else if (rd_fire)        rd_addr <= (rd_addr == LAST) ? '0 : rd_addr + AW'(1);
    end

    // Valid flag tracks the one-cycle memory read latency.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) rd_valid <= 1'b0;
        else           rd_valid <= rd_fire;
    end
endmodule

// File: rtl/adc_capture_buffer.sv
// Top: one-shot burst capture of paired converter samples into a dual-clock
// memory, with start/done crossing by toggle synchronizers.
// Assumes: rd_clk and adc_clk are unrelated; both resets are applied together.
import cap_pkg::*;
module adc_capture_buffer #(
    parameter int unsigned CH_W  = CAP_CH_W,
    parameter int unsigned DEPTH = CAP_DEPTH,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned EW   = 2 * CH_W
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          start_req,
    output logic          busy,
    output logic          done,
    input  logic          rd_en,
    output logic          rd_valid,
    output logic [EW-1:0] rd_data,
    input  logic          adc_clk,
    input  logic          adc_rst_n,
    input  logic [CH_W-1:0] adc_ch_a,
    input  logic [CH_W-1:0] adc_ch_b
);
    logic          start_tog, start_evt, done_tog, done_evt;
    logic          wr_busy, rd_fire;
    logic [AW-1:0] wr_addr, rd_addr;

    cap_toggle_sync #(.STAGES(CAP_SYNC_STAGES)) u_start_sync (
        .clk(adc_clk), .rst_n(adc_rst_n), .tog_in(start_tog), .pulse(start_evt));

    cap_toggle_sync #(.STAGES(CAP_SYNC_STAGES)) u_done_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .tog_in(done_tog), .pulse(done_evt));

    cap_write_ctrl #(.DEPTH(DEPTH)) u_wr (
        .adc_clk(adc_clk), .adc_rst_n(adc_rst_n), .start_evt(start_evt),
        .wr_busy(wr_busy), .wr_addr(wr_addr), .done_tog(done_tog));

    cap_read_ctrl #(.DEPTH(DEPTH)) u_rd (
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .start_req(start_req),
        .done_evt(done_evt), .rd_en(rd_en), .start_tog(start_tog),
        .armed(busy), .done_q(done), .rd_fire(rd_fire),
        .rd_addr(rd_addr), .rd_valid(rd_valid));

    cap_dpram #(.WIDTH(EW), .DEPTH(DEPTH)) u_mem (
        .wr_clk(adc_clk), .wr_en(wr_busy), .wr_addr(wr_addr),
        .wr_data({adc_ch_a, adc_ch_b}),
        .rd_clk(rd_clk), .rd_en(rd_fire), .rd_addr(rd_addr), .rd_data(rd_data));
endmodule

// File: rtl/cap_capture_chk.sv
// Checker: temporal properties of the capture buffer, bound to the top.
// Assumes: connected to the top's ports and its internal control nets.
module cap_capture_chk #(
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          adc_clk,
    input logic          adc_rst_n,
    input logic          start_req,
    input logic          busy,
    input logic          done,
    input logic          rd_en,
    input logic          rd_valid,
    input logic          start_tog,
    input logic [AW-1:0] rd_addr,
    input logic          wr_busy,
    input logic [AW-1:0] wr_addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    a_r4_busy_done_excl: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !(busy && done));
    a_r3_start_arms: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (start_req && !busy) |=> (busy && !done));
    a_r5_ignore_busy: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (start_req && busy) |=> $stable(start_tog));
    a_r6_no_early_read: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && !done) |=> (!rd_valid && $stable(rd_addr)));
    a_r7_read_latency: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && done) |=> rd_valid);
    a_r8_addr_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && done && !start_req) |=>
        (rd_addr == (($past(rd_addr) == LAST) ? '0 : AW'($past(rd_addr) + AW'(1)))));
    a_r2_burst_len: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
        $fell(wr_busy) |-> ($past(wr_addr) == LAST));
    a_r2_burst_step: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
        (wr_busy && wr_addr != LAST) |=> (wr_busy && wr_addr == AW'($past(wr_addr) + AW'(1))));
    a_r2_burst_from_zero: assert property (@(posedge adc_clk) disable iff (!adc_rst_n)
        $rose(wr_busy) |-> (wr_addr == '0));
endmodule

bind adc_capture_buffer cap_capture_chk #(.DEPTH(DEPTH)) u_chk (
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .adc_clk(adc_clk), .adc_rst_n(adc_rst_n),
    .start_req(start_req), .busy(busy), .done(done), .rd_en(rd_en),
    .rd_valid(rd_valid), .start_tog(start_tog), .rd_addr(rd_addr),
    .wr_busy(wr_busy), .wr_addr(wr_addr));

// File: tb/sim_adc_capture_buffer.sv
// Bench: ramp stimulus per table row, full read-back chain, then directed cases.
module sim_adc_capture_buffer;
    localparam int unsigned CH_W  = 12;
    localparam int unsigned DEPTH = 8;
    localparam int unsigned NROW  = 3;
    // Row fields: {a_base, b_base, b_step}; channel A ramps by 1 per converter clock.
    localparam logic [35:0] PAT [NROW] = '{
        {12'h000, 12'h064, 12'h001},
        {12'h7FC, 12'h800, 12'h003},
        {12'hFFA, 12'h005, 12'hFFF}};

    logic rd_clk = 0, adc_clk = 0;
    logic rd_rst_n = 0, adc_rst_n = 0;
    logic start_req = 0, rd_en = 0;
    logic busy, done, rd_valid;
    logic [2*CH_W-1:0] rd_data;
    logic [CH_W-1:0] ch_a, ch_b, n = '0;
    logic [CH_W-1:0] cur_a = '0, cur_b = '0, cur_s = '0;
    int checks = 0, fails = 0;
    bit finished = 0;
    logic [2*CH_W-1:0] first_entry;

    always #10 rd_clk  = ~rd_clk;
    always #8  adc_clk = ~adc_clk;

    always @(negedge adc_clk) n <= n + 12'd1;
    assign ch_a = cur_a + n;
    assign ch_b = CH_W'(cur_b + cur_s * n);

    adc_capture_buffer #(.CH_W(CH_W), .DEPTH(DEPTH)) u0 (
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .start_req(start_req),
        .busy(busy), .done(done), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .adc_clk(adc_clk), .adc_rst_n(adc_rst_n),
        .adc_ch_a(ch_a), .adc_ch_b(ch_b));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge rd_clk) start_req = 1;
        @(negedge rd_clk) start_req = 0;
    endtask

    task automatic read_one(output logic [2*CH_W-1:0] d, output logic v);
        @(negedge rd_clk) rd_en = 1;
        @(negedge rd_clk) rd_en = 0;
        v = rd_valid;
        d = rd_data;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (busy && cyc < 5000) begin
            @(negedge rd_clk);
            cyc++;
        end
    endtask

    // One capture plus one full read pass and a wrap read.
    task automatic run_row(input int r);
        logic [2*CH_W-1:0] d, prev, e0;
        logic v;
        int cyc;
        cur_a = PAT[r][35:24]; cur_b = PAT[r][23:12]; cur_s = PAT[r][11:0];
        pulse_start();
        chk(busy === 1'b1 && done === 1'b0, "R3 start arms busy", {busy, done}, 2'b10);
        wait_done(cyc);
        chk(done === 1'b1 && busy === 1'b0, "R4 done on busy fall", {busy, done}, 2'b01);
        chk(cyc * 20 >= DEPTH * 16, "R4 busy spans burst", cyc, DEPTH * 16 / 20);
        prev = '0; e0 = '0;
        for (int i = 0; i < DEPTH; i++) begin
            read_one(d, v);
            chk(v === 1'b1, "R7 valid after one cycle", v, 1);
            chk(d[11:0] === CH_W'(cur_b + cur_s * (d[23:12] - cur_a)), "R1 pair packing", d, cur_b);
            if (i == 0) e0 = d;
            else chk(d[23:12] === prev[23:12] + 12'd1, "R2 R8 consecutive entries", d[23:12], prev[23:12] + 12'd1);
            prev = d;
        end
        read_one(d, v);
        chk(d === e0, "R8 wrap to entry 0", d, e0);
        first_entry = e0;
    endtask

    initial begin
        repeat (2000000) @(posedge rd_clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [2*CH_W-1:0] d;
        logic v;
        int cyc;
        repeat (4) @(negedge rd_clk);
        chk(busy === 1'b0 && done === 1'b0 && rd_valid === 1'b0, "R9 in reset", {busy, done, rd_valid}, 0);
        rd_rst_n = 1; adc_rst_n = 1;
        repeat (3) @(negedge rd_clk);
        chk(busy === 1'b0 && done === 1'b0 && rd_valid === 1'b0, "R9 after reset", {busy, done, rd_valid}, 0);
        read_one(d, v);
        chk(v === 1'b0, "R6 read ignored before any capture", v, 0);

        for (int r = 0; r < NROW; r++) run_row(r);

        // R6: read strobe during a capture is ignored; R5: second start while busy ignored.
        cur_a = 12'h100; cur_b = 12'h000; cur_s = 12'h002;
        pulse_start();
        read_one(d, v);
        chk(v === 1'b0, "R6 read ignored while busy", v, 0);
        pulse_start();
        wait_done(cyc);
        chk(done === 1'b1, "R4 done after capture", done, 1);
        repeat (40) @(negedge rd_clk);
        chk(busy === 1'b0 && done === 1'b1, "R5 no extra capture", {busy, done}, 2'b01);
        read_one(d, v);
        chk(v === 1'b1, "R6 address unmoved by early reads", v, 1);
        first_entry = d;
        for (int i = 1; i < DEPTH; i++) begin
            read_one(d, v);
            chk(d[23:12] === first_entry[23:12] + 12'(i), "R6 R8 chain from entry 0", d[23:12], first_entry[23:12] + 12'(i));
        end
        // R2: contents stay fixed long after the burst ends.
        repeat (100) @(negedge adc_clk);
        read_one(d, v);
        chk(d === first_entry, "R2 contents stable after burst", d, first_entry);

        finished = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule